// File: doc/BRIEF.md
# Shadow Register Transfer Controller

This block moves a lane configuration word between one host-visible shadow register and the private configuration registers of a group of SerDes macros. The host writes a control word that holds two things. The first is a select mask with one bit per macro. The second is one of two self-clearing operation bits. The load operation copies macro settings into the shadow word. The commit operation copies the shadow word out to every selected macro.

The block serves the selected macros one after another. Each transfer is a fixed-length serial shift of the full shadow word over a simple per-macro port: an enable per macro, a shared data line out, one data line back from each macro, a direction flag, and a strobe on the final bit. While a transfer is running, the operation bit reads back as set. Software polls it and treats the bit dropping as completion. One instance is placed for each macro group, and each instance has its own control word.

Top module: `srt_ctrl`

## Requirements
- R1: After reset the control word reads 0, the shadow word reads 0 and no macro enable is active.
- R2: Control word layout: bits [NMAC-1:0] are the select mask (bit n addresses macro n), bit NMAC is the load operation and bit NMAC+1 is the commit operation. Both are set by one host write together with the mask. From the cycle after that write, the word reads back the mask and the set operation bits until the work completes.
- R3: Each macro transfer keeps exactly one enable high for SHW consecutive cycles. It moves the shadow bits LSB first, one per cycle, and pulses the strobe only in the last of those cycles.
- R4: After a commit, every selected macro holds the shadow word and unselected macros are unchanged.
- R5: After a load, the shadow word holds the value of the selected macro. When several macros are selected, the shadow word holds the value of the highest-indexed one, and every macro keeps its own value.
- R6: Selected macros are served in ascending index order with no gaps. The operation bit clears only after the last one, so it reads busy for exactly (selected count)×SHW polls.
- R7: When both operation bits are written together, the whole load phase completes before any commit transfer begins. Every selected macro then ends with the highest selected macro's old value.
- R8: Host writes to the control word or the shadow word while an operation is pending are ignored.
- R9: A control write with operation bits set but an empty select mask starts nothing, and the operation bits read back as 0.
- R10: While idle, the host can write the shadow word and read it back. Bits above SHW read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | 0 selects the control word, 1 selects the shadow word |
| host_wdata_i | input | HDW | Host write data |
| host_rdata_o | output | HDW | Host read data of the addressed word (combinational) |
| mac_en_o | output | NMAC | One-hot enable of the macro being served |
| mac_dir_o | output | 1 | 1 = commit (shadow to macro), 0 = load (macro to shadow) |
| mac_sdo_o | output | 1 | Serial data to the macros |
| mac_strobe_o | output | 1 | High during the final bit of a transfer |
| mac_sdi_i | input | NMAC | Serial data from each macro |

## Verification
The hardest case to reach is the combined load-then-commit over several macros. A fault there, such as a commit running against a half-loaded shadow word or an early clear of the load bit, only shows up in the final macro contents and the transfer order. The bench first gives two macros distinct values through its register-file models. It then issues both operation bits in one write and checks the logged sequence of served macros and directions, the busy duration, and that both macros end with the higher one's old value. A second case writes the control word and the shadow word in the middle of a commit to prove that they are locked.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } srt_state_e;
endpackage

// File: rtl/srt_lowbit.sv
module srt_lowbit #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign seen[i+1] = seen[i] | req_i[i];
    assign gnt_o[i]  = req_i[i] & ~seen[i];
  end
endmodule

// File: rtl/srt_fsm.sv
module srt_fsm import srt_pkg::*; #(
  parameter int NMAC = 4,
  parameter int SHW  = 16,
  localparam int CW  = (SHW > 1) ? $clog2(SHW) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NMAC-1:0] sel_i,
  input  logic            rd_i,
  input  logic            wr_i,
  output logic [NMAC-1:0] sel_o,
  output logic            busy_rd_o,
  output logic            busy_wr_o,
  output logic [NMAC-1:0] en_o,
  output logic            dir_o,
  output logic            strobe_o,
  output logic [CW-1:0]   bit_o
);
  localparam logic [CW-1:0] LAST = CW'(SHW - 1);

  srt_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic [NMAC-1:0] pend_q, gnt, pend_rest;

  srt_lowbit #(.N(NMAC)) u_pri (.req_i(pend_q), .gnt_o(gnt));

  assign pend_rest = pend_q & ~gnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pend_q    <= '0;
      sel_o     <= '0;
      busy_rd_o <= 1'b0;
      busy_wr_o <= 1'b0;
      dir_o     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sel_o     <= sel_i;
          pend_q    <= sel_i;
          busy_rd_o <= rd_i;
          busy_wr_o <= wr_i;
          dir_o     <= ~rd_i;   // load phase runs first
          cnt_q     <= '0;
          state_q   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (cnt_q == LAST) begin
            cnt_q  <= '0;
            pend_q <= pend_rest;
            if (pend_rest == '0) begin
              if (!dir_o && busy_wr_o) begin
                busy_rd_o <= 1'b0;
                dir_o     <= 1'b1;
                pend_q    <= sel_o;
              end else begin
                busy_rd_o <= 1'b0;
                busy_wr_o <= 1'b0;
                state_q   <= ST_IDLE;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign en_o     = (state_q == ST_SHIFT) ? gnt : '0;
  assign strobe_o = (state_q == ST_SHIFT) && (cnt_q == LAST);
  assign bit_o    = cnt_q;
endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl #(
  parameter int NMAC = 4,
  parameter int SHW  = 16,
  parameter int HDW  = 32,
  localparam int CW  = (SHW > 1) ? $clog2(SHW) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_we_i,
  input  logic            host_addr_i,
  input  logic [HDW-1:0]  host_wdata_i,
  output logic [HDW-1:0]  host_rdata_o,
  output logic [NMAC-1:0] mac_en_o,
  output logic            mac_dir_o,
  output logic            mac_sdo_o,
  output logic            mac_strobe_o,
  input  logic [NMAC-1:0] mac_sdi_i
);
  logic [NMAC-1:0] sel_q, sel_in;
  logic            busy_rd, busy_wr, busy;
  logic            op_rd, op_wr, ctrl_wr, sh_wr, start;
  logic [CW-1:0]   bit_idx;
  logic [SHW-1:0]  shadow_q;
  logic            sdi_bit;

  assign busy    = busy_rd | busy_wr;
  assign sel_in  = host_wdata_i[NMAC-1:0];
  assign op_rd   = host_wdata_i[NMAC];
  assign op_wr   = host_wdata_i[NMAC+1];
  assign ctrl_wr = host_we_i & ~host_addr_i & ~busy;
  assign sh_wr   = host_we_i &  host_addr_i & ~busy;
  assign start   = ctrl_wr & (op_rd | op_wr) & (|sel_in);

  srt_fsm #(.NMAC(NMAC), .SHW(SHW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .sel_i     (sel_in),
    .rd_i      (op_rd),
    .wr_i      (op_wr),
    .sel_o     (sel_q),
    .busy_rd_o (busy_rd),
    .busy_wr_o (busy_wr),
    .en_o      (mac_en_o),
    .dir_o     (mac_dir_o),
    .strobe_o  (mac_strobe_o),
    .bit_o     (bit_idx)
  );

  assign sdi_bit = |(mac_sdi_i & mac_en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          shadow_q <= '0;
    else if (!mac_dir_o && |mac_en_o)     shadow_q <= {sdi_bit, shadow_q[SHW-1:1]};
    else if (sh_wr)                       shadow_q <= host_wdata_i[SHW-1:0];
  end

  assign mac_sdo_o = shadow_q[bit_idx];

  always_comb begin
    host_rdata_o = '0;
    if (host_addr_i) host_rdata_o[SHW-1:0]  = shadow_q;
    else             host_rdata_o[NMAC+1:0] = {busy_wr, busy_rd, sel_q};
  end
endmodule

// File: rtl/srt_ctrl_chk.sv
module srt_ctrl_chk #(
  parameter int NMAC = 4,
  parameter int SHW  = 16,
  localparam int CW  = (SHW > 1) ? $clog2(SHW) : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NMAC-1:0] en_i,
  input logic            strobe_i,
  input logic            dir_i,
  input logic [NMAC-1:0] sel_i,
  input logic            busy_rd_i,
  input logic            busy_wr_i
);
  localparam logic [CW-1:0] LAST = CW'(SHW - 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (en_i != '0 && !strobe_i) run_q <= run_q + 1'b1;
    else                          run_q <= '0;
  end

  a_r3_en_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_i));
  a_r3_strobe_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> (en_i != '0 && run_q == LAST));
  a_r3_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i != '0 && run_q == LAST) |-> strobe_i);
  a_r6_en_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i & ~sel_i) == '0);
  a_r7_load_before_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_rd_i |-> !dir_i);
  a_r7_commit_needs_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && en_i != '0) |-> busy_wr_i);
  a_r8_sel_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((busy_rd_i || busy_wr_i) && $past(busy_rd_i || busy_wr_i)) |-> $stable(sel_i));
endmodule

bind srt_ctrl srt_ctrl_chk #(.NMAC(NMAC), .SHW(SHW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (mac_en_o),
  .strobe_i  (mac_strobe_o),
  .dir_i     (mac_dir_o),
  .sel_i     (sel_q),
  .busy_rd_i (busy_rd),
  .busy_wr_i (busy_wr)
);

// File: tb/sim_srt_ctrl.sv
module sim_srt_ctrl;
  localparam int NMAC = 4;
  localparam int SHW  = 16;
  localparam int HDW  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0, addr = 1'b0;
  logic [HDW-1:0]  wdata = '0;
  logic [HDW-1:0]  rdata;
  logic [NMAC-1:0] en, sdi;
  logic            dir, sdo, strobe;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  srt_ctrl #(.NMAC(NMAC), .SHW(SHW), .HDW(HDW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .mac_en_o(en),
    .mac_dir_o(dir), .mac_sdo_o(sdo), .mac_strobe_o(strobe), .mac_sdi_i(sdi));

  // macro register-file models
  logic [SHW-1:0]  cfg [NMAC];
  logic [SHW-1:0]  sr  [NMAC];
  logic [NMAC-1:0] pre_we = '0;
  logic [SHW-1:0]  pre_val = '0;

  always_comb for (int k = 0; k < NMAC; k++) sdi[k] = cfg[k][0];

  always @(posedge clk) begin
    for (int k = 0; k < NMAC; k++) begin
      if (pre_we[k]) cfg[k] <= pre_val;
      else if (en[k]) begin
        if (dir) begin
          sr[k] <= {sdo, sr[k][SHW-1:1]};
          if (strobe) cfg[k] <= {sdo, sr[k][SHW-1:1]};
        end else cfg[k] <= {cfg[k][0], cfg[k][SHW-1:1]};
      end
    end
  end

  // transfer log
  int   log_mac [16];
  logic log_dir [16];
  int   log_n = 0, en_cyc = 0;
  logic clr = 1'b0;

  always @(posedge clk) begin
    if (clr) begin
      log_n <= 0; en_cyc <= 0;
    end else begin
      if (en != '0) en_cyc <= en_cyc + 1;
      if (strobe && log_n < 16) begin
        for (int k = 0; k < NMAC; k++) if (en[k]) log_mac[log_n] <= k;
        log_dir[log_n] <= dir;
        log_n <= log_n + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [HDW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [HDW-1:0] d);
    addr = a; #1; d = rdata; addr = 1'b0;
  endtask

  task automatic preset(input int k, input logic [SHW-1:0] v);
    @(negedge clk); pre_we = '0; pre_we[k] = 1'b1; pre_val = v;
    @(negedge clk); pre_we = '0;
  endtask

  task automatic clear_log();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // call right after host_wr that started work; returns busy poll count
  task automatic wait_idle(output int n);
    logic [HDW-1:0] d;
    n = 0;
    forever begin
      host_rd(1'b0, d);
      if (d[NMAC+1:NMAC] == 2'b00) break;
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [HDW-1:0] ctl(input logic w, input logic r, input logic [NMAC-1:0] s);
    ctl = '0; ctl[NMAC+1] = w; ctl[NMAC] = r; ctl[NMAC-1:0] = s;
  endfunction

  task automatic t_reset();
    logic [HDW-1:0] d;
    @(negedge clk);
    host_rd(1'b0, d); chk("R1 ctrl", d, 0);
    host_rd(1'b1, d); chk("R1 shadow", d, 0);
    chk("R1 enables", en, 0);
  endtask

  task automatic t_shadow_rw();
    logic [HDW-1:0] d;
    host_wr(1'b1, 32'hFFFF_A5C3);
    host_rd(1'b1, d); chk("R10 shadow readback", d, 32'h0000_A5C3);
  endtask

  task automatic t_commit_single();
    logic [HDW-1:0] d; int n;
    for (int k = 0; k < NMAC; k++) preset(k, SHW'(16'h0F00 + k));
    host_wr(1'b1, 32'h1234);
    clear_log();
    host_wr(1'b0, ctl(1, 0, 4'b0010));
    host_rd(1'b0, d); chk("R2 busy readback", d, ctl(1, 0, 4'b0010));
    wait_idle(n);
    chk("R6 busy polls single", n, SHW);
    host_rd(1'b0, d); chk("R2 idle readback", d, ctl(0, 0, 4'b0010));
    chk("R4 macro1 committed", cfg[1], 16'h1234);
    chk("R4 macro0 untouched", cfg[0], 16'h0F00);
    chk("R4 macro2 untouched", cfg[2], 16'h0F02);
    chk("R3 enable cycles", en_cyc, SHW);
    chk("R3 strobe count", log_n, 1);
  endtask

  task automatic t_commit_multi();
    int n;
    host_wr(1'b1, 32'hBEEF);
    clear_log();
    host_wr(1'b0, ctl(1, 0, 4'b1011));
    wait_idle(n);
    chk("R6 busy polls multi", n, 3 * SHW);
    chk("R4 macro0", cfg[0], 16'hBEEF);
    chk("R4 macro1", cfg[1], 16'hBEEF);
    chk("R4 macro3", cfg[3], 16'hBEEF);
    chk("R4 macro2 unselected", cfg[2], 16'h0F02);
    chk("R6 transfers", log_n, 3);
    chk("R6 order first", log_mac[0], 0);
    chk("R6 order second", log_mac[1], 1);
    chk("R6 order third", log_mac[2], 3);
    chk("R3 enable cycles multi", en_cyc, 3 * SHW);
  endtask

  task automatic t_load();
    logic [HDW-1:0] d; int n;
    preset(2, 16'h5A5A);
    host_wr(1'b0, ctl(0, 1, 4'b0100));
    wait_idle(n);
    chk("R6 busy polls load", n, SHW);
    host_rd(1'b1, d); chk("R5 shadow loaded", d, 32'h5A5A);
    chk("R5 macro kept", cfg[2], 16'h5A5A);
    preset(0, 16'h1111); preset(3, 16'h3333);
    host_wr(1'b0, ctl(0, 1, 4'b1001));
    wait_idle(n);
    host_rd(1'b1, d); chk("R5 highest wins", d, 32'h3333);
    chk("R5 macro0 kept", cfg[0], 16'h1111);
  endtask

  task automatic t_both();
    logic [HDW-1:0] d; int n;
    preset(1, 16'h7777); preset(2, 16'h2222);
    host_wr(1'b1, 32'h0);
    clear_log();
    host_wr(1'b0, ctl(1, 1, 4'b0110));
    host_rd(1'b0, d); chk("R2 both bits busy", d, ctl(1, 1, 4'b0110));
    wait_idle(n);
    chk("R7 busy polls", n, 4 * SHW);
    host_rd(1'b1, d); chk("R7 shadow", d, 32'h2222);
    chk("R7 macro1", cfg[1], 16'h2222);
    chk("R7 macro2", cfg[2], 16'h2222);
    chk("R7 transfers", log_n, 4);
    chk("R7 seq0", {log_mac[0][7:0], 7'd0, log_dir[0]}, {8'd1, 8'd0});
    chk("R7 seq1", {log_mac[1][7:0], 7'd0, log_dir[1]}, {8'd2, 8'd0});
    chk("R7 seq2", {log_mac[2][7:0], 7'd0, log_dir[2]}, {8'd1, 8'd1});
    chk("R7 seq3", {log_mac[3][7:0], 7'd0, log_dir[3]}, {8'd2, 8'd1});
  endtask

  task automatic t_ignore();
    logic [HDW-1:0] d; int n;
    preset(3, 16'h3C3C);
    host_wr(1'b1, 32'h00C5);
    host_wr(1'b0, ctl(1, 0, 4'b0001));
    host_wr(1'b0, ctl(1, 0, 4'b1000));
    host_wr(1'b1, 32'hFFFF);
    host_rd(1'b0, d); chk("R8 ctrl locked", d, ctl(1, 0, 4'b0001));
    wait_idle(n);
    host_rd(1'b1, d); chk("R8 shadow locked", d, 32'h00C5);
    chk("R8 macro0 got original", cfg[0], 16'h00C5);
    chk("R8 macro3 untouched", cfg[3], 16'h3C3C);
  endtask

  task automatic t_zero_sel();
    logic [HDW-1:0] d;
    clear_log();
    host_wr(1'b0, ctl(1, 1, 4'b0000));
    host_rd(1'b0, d); chk("R9 no op bits", d[NMAC+1:NMAC], 0);
    repeat (SHW + 2) @(negedge clk);
    chk("R9 no enables", en_cyc, 0);
  endtask

  initial begin
    for (int k = 0; k < NMAC; k++) begin cfg[k] = '0; sr[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow_rw();
    t_commit_single();
    t_commit_multi();
    t_load();
    t_both();
    t_ignore();
    t_zero_sel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule